// File: doc/BRIEF.md
# Operand Address Generator

This block resolves where one instruction operand lives. A decode stage gives it one operand specifier per cycle: a mode code, a register index, the current contents of that register, the extension word that follows the instruction word, a byte/word size select and a flag that says whether the operand is read (source) or written (destination). One clock later the block reports one of three result kinds. It can name a register, give an effective memory address together with a read request, or give an immediate value. In auto-increment mode it also issues a register write-back request.

Specifiers that make no sense are flagged as illegal. These are the unused mode codes, and the immediate, indirect and auto-increment modes used as a destination. An illegal specifier requests no memory read and no write-back. An indexed specifier with a zero offset is still accepted as a destination, so software can reach the location that a plain indirect specifier would name.

A small load formatter completes the path. When the memory returns a word for the most recent memory operand, the block passes it through as it is for a word access. For a byte access it extracts the addressed byte, zero-extended. All address arithmetic wraps at the data width.

Top module: `opnd_addr_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid`, `out_illegal`, `out_misalign`, `out_rd`, `out_wb` and `fmt_valid` are 0.
- R2: Mode code 0 (register) is legal as a source and as a destination. The result is kind 1 (register) with `out_reg` equal to the register index, and neither a memory read nor a write-back is requested.
- R3: Mode code 5 (immediate) as a source gives kind 3 (immediate) with `out_imm` equal to the extension word. As a destination it is illegal.
- R4: Mode code 2 (absolute) gives kind 2 (memory) with `out_addr` equal to the extension word and `out_rd` set, for both a source and a destination.
- R5: Mode code 3 (register indirect) as a source gives kind 2 with `out_addr` equal to the register contents. As a destination it is illegal.
- R6: Mode code 4 (auto-increment) as a source gives kind 2 with `out_addr` equal to the register contents. It also sets `out_wb`, with `out_wb_reg` equal to the register index and `out_wb_val` equal to the contents plus 2 for a word or plus 1 for a byte. As a destination it is illegal.
- R7: Mode code 1 (indexed) gives kind 2 with `out_addr` equal to the register contents plus the extension word. It is legal as a destination, including with a zero offset.
- R8: Every address and write-back sum wraps modulo 2^16. For example, FFFEh + 4 gives 0002h, and a byte auto-increment of FFFFh gives 0000h.
- R9: `out_misalign` is 1 only for a legal word-sized memory result whose address is odd. A byte access never raises it.
- R10: Mode codes 6 and 7, and the destination cases in R3, R5 and R6, set `out_illegal`. In that case the kind is 0 (none), and `out_rd` and `out_wb` are 0.
- R11: A request with `req_valid` high produces exactly one result with `out_valid` high one clock later, and results come out in request order. Without a request `out_valid` is 0. Every field that does not belong to the result kind reads zero.
- R12: `fmt_valid` follows `rd_valid` one clock later. `fmt_data` holds the whole returned word for a word operand. For a byte operand it holds the addressed byte of the returned word, zero-extended: the low byte at an even address and the high byte at an odd address. The operand used is the most recent memory result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Specifier present this cycle |
| req_mode | input | 3 | Mode code (0 reg, 1 indexed, 2 absolute, 3 indirect, 4 auto-increment, 5 immediate) |
| req_reg | input | RW (4) | Register index |
| req_reg_val | input | DW (16) | Contents of the indexed register |
| req_ext | input | DW (16) | Extension word: offset, address or immediate |
| req_byte | input | 1 | 1 = byte operand, 0 = word operand |
| req_dest | input | 1 | 1 = destination, 0 = source |
| out_valid | output | 1 | Result present |
| out_kind | output | 2 | 0 none, 1 register, 2 memory, 3 immediate |
| out_reg | output | RW (4) | Selected register (register kind) |
| out_addr | output | DW (16) | Effective address (memory kind) |
| out_rd | output | 1 | Memory read request |
| out_imm | output | DW (16) | Immediate value (immediate kind) |
| out_wb | output | 1 | Register write-back request |
| out_wb_reg | output | RW (4) | Register to write back |
| out_wb_val | output | DW (16) | Value to write back |
| out_illegal | output | 1 | Specifier rejected |
| out_misalign | output | 1 | Word access at an odd address |
| rd_valid | input | 1 | Memory data returned this cycle |
| rd_word | input | DW (16) | Returned memory word |
| fmt_valid | output | 1 | Formatted operand data present |
| fmt_data | output | DW (16) | Operand data, byte-extracted when needed |

## Verification
Every specifier result is due on the first rising edge after the request. The formatted load data is due on the first rising edge after `rd_valid`. The driver queues one expected result per request, and the monitor compares at each falling edge where `out_valid` is high. The comparison happens half a period after the edge that loaded the result, so it never races the update. A result with nothing queued is a failure, and so is a queue left with items at the end. This catches both missing and extra results, including for back-to-back requests. The formatter is checked at the falling edge exactly one clock after the returned word is presented.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  // mode codes seen on req_mode
  localparam logic [2:0] AM_REG = 3'd0;
  localparam logic [2:0] AM_IDX = 3'd1;
  localparam logic [2:0] AM_ABS = 3'd2;
  localparam logic [2:0] AM_IND = 3'd3;
  localparam logic [2:0] AM_INC = 3'd4;
  localparam logic [2:0] AM_IMM = 3'd5;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_REG  = 2'd1,
    K_MEM  = 2'd2,
    K_IMM  = 2'd3
  } opnd_kind_e;
endpackage

// File: rtl/opnd_mode_dec.sv
module opnd_mode_dec
  import opnd_pkg::*;
(
  input  logic [2:0]  mode,
  input  logic        is_dest,
  output opnd_kind_e  kind,
  output logic        illegal,
  output logic        use_base,
  output logic        add_ext,
  output logic        do_wb
);
  always_comb begin
    kind     = K_NONE;
    illegal  = 1'b0;
    use_base = 1'b0;
    add_ext  = 1'b0;
    do_wb    = 1'b0;
    case (mode)
      AM_REG: kind = K_REG;
      AM_IDX: begin
        kind     = K_MEM;
        use_base = 1'b1;
        add_ext  = 1'b1;
      end
      AM_ABS: kind = K_MEM;
      AM_IND: begin
        kind     = K_MEM;
        use_base = 1'b1;
      end
      AM_INC: begin
        kind     = K_MEM;
        use_base = 1'b1;
        do_wb    = 1'b1;
      end
      AM_IMM: kind = K_IMM;
      default: illegal = 1'b1;
    endcase
    // destination may not be a constant nor a pointer-only form
    if (is_dest && (mode == AM_IMM || mode == AM_IND || mode == AM_INC))
      illegal = 1'b1;
    if (illegal) begin
      kind  = K_NONE;
      do_wb = 1'b0;
    end
  end
endmodule

// File: rtl/opnd_ea_calc.sv
module opnd_ea_calc #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] reg_val,
  input  logic [DW-1:0] ext,
  input  logic          use_base,
  input  logic          add_ext,
  input  logic          is_byte,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] wb_val,
  output logic          odd_word
);
  localparam int WORD_BYTES = DW / 8;
  localparam int LANE_W     = $clog2(WORD_BYTES);

  logic [DW-1:0] offs;
  logic [DW-1:0] step;

  always_comb begin
    offs     = add_ext ? ext : '0;
    ea       = use_base ? (reg_val + offs) : ext;
    step     = is_byte ? DW'(1) : DW'(WORD_BYTES);
    wb_val   = reg_val + step;
    odd_word = !is_byte && (ea[LANE_W-1:0] != '0);
  end
endmodule

// File: rtl/opnd_load_fmt.sv
module opnd_load_fmt #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]              word_in,
  input  logic                       is_byte,
  input  logic [$clog2(DW/8)-1:0]    lane,
  output logic [DW-1:0]              word_out
);
  localparam int LANES  = DW / 8;
  localparam int LANE_W = $clog2(LANES);

  always_comb begin
    word_out = '0;
    if (!is_byte) begin
      word_out = word_in;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (lane == LANE_W'(i)) word_out[7:0] = word_in[8*i +: 8];
      end
    end
  end
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import opnd_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic [RW-1:0] req_reg,
  input  logic [DW-1:0] req_reg_val,
  input  logic [DW-1:0] req_ext,
  input  logic          req_byte,
  input  logic          req_dest,
  output logic          out_valid,
  output logic [1:0]    out_kind,
  output logic [RW-1:0] out_reg,
  output logic [DW-1:0] out_addr,
  output logic          out_rd,
  output logic [DW-1:0] out_imm,
  output logic          out_wb,
  output logic [RW-1:0] out_wb_reg,
  output logic [DW-1:0] out_wb_val,
  output logic          out_illegal,
  output logic          out_misalign,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_word,
  output logic          fmt_valid,
  output logic [DW-1:0] fmt_data
);
  localparam int LANE_W = $clog2(DW / 8);

  opnd_kind_e    dec_kind;
  logic          dec_illegal, dec_base, dec_add, dec_wb;
  logic [DW-1:0] ea, wb_sum, fmt_comb;
  logic          odd_word;
  logic [LANE_W-1:0] last_lane;
  logic          last_byte;

  opnd_mode_dec dec_i (
    .mode     (req_mode),
    .is_dest  (req_dest),
    .kind     (dec_kind),
    .illegal  (dec_illegal),
    .use_base (dec_base),
    .add_ext  (dec_add),
    .do_wb    (dec_wb)
  );

  opnd_ea_calc #(.DW(DW)) ea_i (
    .reg_val  (req_reg_val),
    .ext      (req_ext),
    .use_base (dec_base),
    .add_ext  (dec_add),
    .is_byte  (req_byte),
    .ea       (ea),
    .wb_val   (wb_sum),
    .odd_word (odd_word)
  );

  opnd_load_fmt #(.DW(DW)) fmt_i (
    .word_in  (rd_word),
    .is_byte  (last_byte),
    .lane     (last_lane),
    .word_out (fmt_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_kind     <= K_NONE;
      out_reg      <= '0;
      out_addr     <= '0;
      out_rd       <= 1'b0;
      out_imm      <= '0;
      out_wb       <= 1'b0;
      out_wb_reg   <= '0;
      out_wb_val   <= '0;
      out_illegal  <= 1'b0;
      out_misalign <= 1'b0;
      last_lane    <= '0;
      last_byte    <= 1'b0;
    end else begin
      out_valid    <= req_valid;
      out_kind     <= K_NONE;
      out_reg      <= '0;
      out_addr     <= '0;
      out_rd       <= 1'b0;
      out_imm      <= '0;
      out_wb       <= 1'b0;
      out_wb_reg   <= '0;
      out_wb_val   <= '0;
      out_illegal  <= 1'b0;
      out_misalign <= 1'b0;
      if (req_valid) begin
        out_kind    <= dec_kind;
        out_illegal <= dec_illegal;
        case (dec_kind)
          K_REG: out_reg <= req_reg;
          K_MEM: begin
            out_addr     <= ea;
            out_rd       <= 1'b1;
            out_misalign <= odd_word;
            last_lane    <= ea[LANE_W-1:0];
            last_byte    <= req_byte;
            if (dec_wb) begin
              out_wb     <= 1'b1;
              out_wb_reg <= req_reg;
              out_wb_val <= wb_sum;
            end
          end
          K_IMM: out_imm <= req_ext;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_valid <= 1'b0;
      fmt_data  <= '0;
    end else begin
      fmt_valid <= rd_valid;
      fmt_data  <= rd_valid ? fmt_comb : '0;
    end
  end
endmodule

// File: rtl/opnd_addr_gen_chk.sv
module opnd_addr_gen_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [2:0]    req_mode,
  input logic          req_byte,
  input logic          req_dest,
  input logic          out_valid,
  input logic [1:0]    out_kind,
  input logic [DW-1:0] out_addr,
  input logic          out_rd,
  input logic          out_wb,
  input logic [DW-1:0] out_wb_val,
  input logic          out_illegal,
  input logic          out_misalign,
  input logic          rd_valid,
  input logic          fmt_valid
);
  localparam int WORD_BYTES = DW / 8;

  // R10
  illegal_no_side_effect_chk: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (!out_rd && !out_wb && out_kind == 2'd0));

  // R11
  result_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  // R11
  no_result_without_req_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  // R6
  autoinc_step_chk: assert property (@(posedge clk) disable iff (rst)
    out_wb |-> (out_wb_val == out_addr + ($past(req_byte) ? DW'(1) : DW'(WORD_BYTES))));

  // R3
  dest_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dest && (req_mode == 3'd5 || req_mode == 3'd3 || req_mode == 3'd4))
      |=> out_illegal);

  // R9
  byte_never_misaligned_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_byte) |=> !out_misalign);

  // R2
  reg_kind_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 2'd1) |-> (!out_rd && !out_wb));

  // R12
  fmt_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> fmt_valid);
endmodule

bind opnd_addr_gen opnd_addr_gen_chk #(.DW(DW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_mode     (req_mode),
  .req_byte     (req_byte),
  .req_dest     (req_dest),
  .out_valid    (out_valid),
  .out_kind     (out_kind),
  .out_addr     (out_addr),
  .out_rd       (out_rd),
  .out_wb       (out_wb),
  .out_wb_val   (out_wb_val),
  .out_illegal  (out_illegal),
  .out_misalign (out_misalign),
  .rd_valid     (rd_valid),
  .fmt_valid    (fmt_valid)
);

// File: tb/opnd_addr_gen_tb_top.sv
`timescale 1ns/1ps
module opnd_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = '0;
  logic [3:0]  req_reg = '0;
  logic [15:0] req_reg_val = '0;
  logic [15:0] req_ext = '0;
  logic        req_byte = 1'b0;
  logic        req_dest = 1'b0;
  logic        out_valid, out_rd, out_wb, out_illegal, out_misalign;
  logic [1:0]  out_kind;
  logic [3:0]  out_reg, out_wb_reg;
  logic [15:0] out_addr, out_imm, out_wb_val;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_word = '0;
  logic        fmt_valid;
  logic [15:0] fmt_data;

  always #2 clk = ~clk;

  opnd_addr_gen dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_reg(req_reg), .req_reg_val(req_reg_val), .req_ext(req_ext),
    .req_byte(req_byte), .req_dest(req_dest), .out_valid(out_valid),
    .out_kind(out_kind), .out_reg(out_reg), .out_addr(out_addr), .out_rd(out_rd),
    .out_imm(out_imm), .out_wb(out_wb), .out_wb_reg(out_wb_reg),
    .out_wb_val(out_wb_val), .out_illegal(out_illegal), .out_misalign(out_misalign),
    .rd_valid(rd_valid), .rd_word(rd_word), .fmt_valid(fmt_valid), .fmt_data(fmt_data)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  rg;
    logic [15:0] addr;
    logic        rd;
    logic [15:0] imm;
    logic        wb;
    logic [3:0]  wbr;
    logic [15:0] wbv;
    logic        ill;
    logic        mis;
  } res_t;

  res_t  exp_q[$];
  string tag_q[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;

  function automatic res_t model(input logic [2:0] m, input logic [3:0] r,
                                 input logic [15:0] v, input logic [15:0] x,
                                 input logic b, input logic d);
    res_t e = '0;
    logic [15:0] a;
    if (m > 3'd5 || (d && (m == 3'd5 || m == 3'd3 || m == 3'd4))) begin
      e.ill = 1'b1;
      return e;
    end
    if (m == 3'd0) begin e.kind = 2'd1; e.rg = r; return e; end
    if (m == 3'd5) begin e.kind = 2'd3; e.imm = x; return e; end
    case (m)
      3'd1:    a = v + x;
      3'd2:    a = x;
      default: a = v;
    endcase
    e.kind = 2'd2; e.addr = a; e.rd = 1'b1;
    e.mis = !b && a[0];
    if (m == 3'd4) begin
      e.wb = 1'b1; e.wbr = r; e.wbv = v + (b ? 16'd1 : 16'd2);
    end
    return e;
  endfunction

  // driver: called at a falling edge, holds the request for one clock
  task automatic send(input string tag, input logic [2:0] m, input logic [3:0] r,
                      input logic [15:0] v, input logic [15:0] x,
                      input logic b, input logic d);
    req_valid = 1'b1; req_mode = m; req_reg = r; req_reg_val = v;
    req_ext = x; req_byte = b; req_dest = d;
    exp_q.push_back(model(m, r, v, x, b, d));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compare each result half a clock after it is loaded
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      res_t act;
      act = '{out_kind, out_reg, out_addr, out_rd, out_imm, out_wb,
              out_wb_reg, out_wb_val, out_illegal, out_misalign};
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R11 unexpected result act=%h exp=none", act);
      end else begin
        res_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          bad++;
          $display("FAIL %s act=%h exp=%h", t, act, e);
        end
      end
    end
  end

  task automatic check_fmt(input string tag, input logic [15:0] addr,
                           input logic b, input logic [15:0] word,
                           input logic [15:0] exp);
    send(tag, 3'd2, 4'd0, 16'h0, addr, b, 1'b0);
    rd_valid = 1'b1; rd_word = word;
    @(negedge clk);
    rd_valid = 1'b0;
    total++;
    if (fmt_valid !== 1'b1 || fmt_data !== exp) begin
      bad++;
      $display("FAIL %s fmt act=%b/%h exp=1/%h", tag, fmt_valid, fmt_data, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is high
    total++;
    if (out_valid || out_illegal || out_misalign || out_rd || out_wb || fmt_valid) begin
      bad++;
      $display("FAIL R1 act=%b%b%b%b%b%b exp=000000", out_valid, out_illegal,
               out_misalign, out_rd, out_wb, fmt_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (out_valid || fmt_valid) begin
      bad++;
      $display("FAIL R1 after release act=%b%b exp=00", out_valid, fmt_valid);
    end

    send("R2 reg src", 3'd0, 4'd3, 16'h1234, 16'h0, 1'b0, 1'b0);
    send("R2 reg dst", 3'd0, 4'd9, 16'h5555, 16'h0, 1'b1, 1'b1);
    send("R3 imm src", 3'd5, 4'd2, 16'h0, 16'h02AC, 1'b0, 1'b0);
    send("R3 imm dst", 3'd5, 4'd2, 16'h0, 16'h02AC, 1'b0, 1'b1);
    @(negedge clk);
    send("R4 abs src", 3'd2, 4'd0, 16'h0, 16'h2340, 1'b0, 1'b0);
    send("R4 abs dst", 3'd2, 4'd0, 16'h0, 16'h2340, 1'b0, 1'b1);
    send("R9 abs odd word", 3'd2, 4'd0, 16'h0, 16'h2341, 1'b0, 1'b0);
    send("R9 abs odd byte", 3'd2, 4'd0, 16'h0, 16'h2341, 1'b1, 1'b0);
    send("R5 ind src", 3'd3, 4'd5, 16'h0308, 16'hFFFF, 1'b0, 1'b0);
    send("R5 ind dst", 3'd3, 4'd5, 16'h0308, 16'h0, 1'b0, 1'b1);
    send("R6 inc word", 3'd4, 4'd5, 16'h0240, 16'h0, 1'b0, 1'b0);
    send("R6 inc byte", 3'd4, 4'd5, 16'h0240, 16'h0, 1'b1, 1'b0);
    send("R6 inc dst", 3'd4, 4'd5, 16'h0240, 16'h0, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    send("R7 idx src", 3'd1, 4'd6, 16'h2340, 16'h0004, 1'b0, 1'b0);
    send("R7 idx dst zero", 3'd1, 4'd6, 16'h2340, 16'h0000, 1'b0, 1'b1);
    send("R8 idx wrap", 3'd1, 4'd6, 16'hFFFE, 16'h0004, 1'b0, 1'b0);
    send("R8 inc wrap", 3'd4, 4'd7, 16'hFFFF, 16'h0, 1'b1, 1'b0);
    send("R10 mode 6", 3'd6, 4'd1, 16'h1111, 16'h2222, 1'b0, 1'b0);
    send("R10 mode 7", 3'd7, 4'd1, 16'h1111, 16'h2222, 1'b1, 1'b1);
    @(negedge clk);
    check_fmt("R12 byte even", 16'h0240, 1'b1, 16'hABCD, 16'h00CD);
    check_fmt("R12 byte odd", 16'h0241, 1'b1, 16'hABCD, 16'h00AB);
    check_fmt("R12 word", 16'h0240, 1'b0, 16'hABCD, 16'hABCD);
    repeat (3) @(negedge clk);
    // R11: every request produced a result
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R11 missing results act=%0d exp=0", exp_q.size());
    end
    finish_run();
  end
endmodule